// File: doc/BRIEF.md
# Interrupt Distributor State Bank

This block keeps the per-interrupt state that an interrupt distributor needs. For each interrupt ID it holds an enable bit, a pending latch, an active bit, a priority byte and a trigger type. The number of IDs is set by a parameter. IDs 0 to 31 are private and the rest are shared. Software reaches the state through a register port that carries a 12-bit byte offset, an access size (byte, halfword or word) and 32 bits of data.

Each interrupt has one level input line. The bank drives the effective pending, enable and priority vectors to a later selection stage, which is outside this block.

Registers, by byte offset:

| Offset | Register | Packing |
|--------|----------|---------|
| 0x000 | enable set | 1 bit per ID |
| 0x080 | enable clear | 1 bit per ID |
| 0x100 | pending set | 1 bit per ID |
| 0x180 | pending clear | 1 bit per ID |
| 0x200 | active set | 1 bit per ID |
| 0x280 | active clear | 1 bit per ID |
| 0x400 | priority | 1 byte per ID |
| 0x800 | trigger configuration | 2 bits per ID |

The first ID that an access covers is its offset within the group, times 8, divided by the bits per ID. Data lanes are little-endian: byte lane n is bits 8n+7..8n of the data word.

Top module: `irq_state_bank`

## Requirements
- R1: In the enable, pending and active set registers, writing 1 to a bit sets that ID's state. A 0 bit leaves the state unchanged.
- R2: In the matching clear registers, writing 1 to a bit clears that ID's state. A 0 bit leaves the state unchanged.
- R3: Reading the set register or the clear register of a pair returns the same current state bits.
- R4: A priority write stores the written byte ANDed with a mask that keeps only the top PRIO_BITS bits. With the default of 5 bits the mask is 0xF8. The low bits always read as 0, both in the register and on irq_prio.
- R5: Each ID has a 2-bit configuration field at bit position 2×(ID mod 16). A read returns 0b10 for edge and 0b00 for level. On a write to a shared ID, only the upper bit of the field is used, and 1 selects edge.
- R6: Configuration writes to IDs below 32 are ignored. IDs 0 to 15 always read as edge and IDs 16 to 31 always read as level.
- R7: A level-type ID shows as pending when its latch is set or its input line is high.
- R8: An edge-type ID latches pending on a rising edge of its input line. The latch stays set after the line falls, until a pending-clear write clears it.
- R9: After reset, all enable, pending-latch, active and priority state is 0, and the shared IDs are level-type.
- R10: A read returns rd_data with rd_valid one cycle after the request. A write takes effect at the clock edge where it is sampled.
- R11: Size encoding is 0 = byte, 1 = halfword, 2 = word. Only the addressed byte lanes take part, and the other lanes read as 0. A misaligned access, or a size of 3, writes nothing and reads 0.
- R12: IDs at or above NUM_IRQ read as 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size (0 byte, 1 half, 2 word) |
| req_addr | input | 12 | Byte offset of the access |
| req_wdata | input | 32 | Write data, lane-aligned |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| irq_line | input | NUM_IRQ | Interrupt input lines |
| irq_pending | output | NUM_IRQ | Effective pending state |
| irq_enable | output | NUM_IRQ | Enable state |
| irq_prio | output | NUM_IRQ*8 | Priority byte per ID |

## Verification
The assertions check the following on every cycle:
- the one-cycle read response;
- the zeroed low priority bits on irq_prio;
- that a private level line always shows as pending;
- that an edge latch on ID 0 holds until a pending-clear write;
- the fixed configuration readback of the private IDs;
- enable set and clear on ID 0.

Only the bench's scenarios can show the following:
- the lane masking and the rejection of misaligned accesses;
- the truncation of particular written priority values;
- the shared-ID configuration writes;
- the out-of-range IDs;
- that the set and clear registers of a pair read back the same bits.

// File: rtl/irq_state_bank.sv
module irq_state_bank #(
  parameter int NUM_IRQ   = 64,
  parameter int PRIO_BITS = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [1:0]           req_size,
  input  logic [11:0]          req_addr,
  input  logic [31:0]          req_wdata,
  output logic                 rd_valid,
  output logic [31:0]          rd_data,
  input  logic [NUM_IRQ-1:0]   irq_line,
  output logic [NUM_IRQ-1:0]   irq_pending,
  output logic [NUM_IRQ-1:0]   irq_enable,
  output logic [NUM_IRQ*8-1:0] irq_prio
);
  localparam int IW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam logic [7:0] PRIO_MASK = 8'(8'hFF << (8 - PRIO_BITS));
  localparam logic [NUM_IRQ-1:0] EDGE_RST = NUM_IRQ'(32'h0000_FFFF);

  logic [NUM_IRQ-1:0] en_q, pd_q, ac_q, edge_q, line_q;
  logic [NUM_IRQ-1:0][7:0] prio_q;
  logic [NUM_IRQ-1:0] en_s, en_c, pd_s, pd_c, ac_s, ac_c, pr_we, cf_we, cf_d, bhit;
  logic [3:0]  lanes;
  logic [31:0] bmask, wdm, rw;
  logic [1:0]  region;
  logic [2:0]  bsel;
  logic        wr_ok;

  assign region = req_addr[11:10];
  assign bsel   = req_addr[9:7];

  always_comb begin
    case (req_size)
      2'd0:    lanes = 4'b0001 << req_addr[1:0];
      2'd1:    lanes = req_addr[0] ? 4'b0000 : (4'b0011 << req_addr[1:0]);
      2'd2:    lanes = (req_addr[1:0] != 2'd0) ? 4'b0000 : 4'b1111;
      default: lanes = 4'b0000;
    endcase
  end

  assign bmask = {{8{lanes[3]}}, {8{lanes[2]}}, {8{lanes[1]}}, {8{lanes[0]}}};
  assign wdm   = req_wdata & bmask;
  assign wr_ok = req_valid && req_write && (lanes != 4'b0000);

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    localparam int BW = i / 32;
    localparam int BB = i % 32;
    localparam int PW = i / 4;
    localparam int PB = i % 4;
    localparam int CW = i / 16;
    localparam int CB = i % 16;

    assign bhit[i]  = wr_ok && (region == 2'd0) && (req_addr[6:2] == 5'(BW)) && wdm[BB];
    assign en_s[i]  = bhit[i] && (bsel == 3'd0);
    assign en_c[i]  = bhit[i] && (bsel == 3'd1);
    assign pd_s[i]  = bhit[i] && (bsel == 3'd2);
    assign pd_c[i]  = bhit[i] && (bsel == 3'd3);
    assign ac_s[i]  = bhit[i] && (bsel == 3'd4);
    assign ac_c[i]  = bhit[i] && (bsel == 3'd5);
    assign pr_we[i] = wr_ok && (region == 2'd1) && (req_addr[9:2] == 8'(PW)) && lanes[PB];

    if (i >= 32) begin : g_shared
      assign cf_we[i] = wr_ok && (region == 2'd2) && (req_addr[9:2] == 8'(CW)) && lanes[CB/4];
      assign cf_d[i]  = req_wdata[2*CB+1];
    end else begin : g_private
      assign cf_we[i] = 1'b0;
      assign cf_d[i]  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      pd_q   <= '0;
      ac_q   <= '0;
      edge_q <= EDGE_RST;
      line_q <= '0;
      prio_q <= '0;
    end else begin
      en_q   <= (en_q & ~en_c) | en_s;
      ac_q   <= (ac_q & ~ac_c) | ac_s;
      pd_q   <= (pd_q & ~pd_c) | pd_s | (irq_line & ~line_q & edge_q);
      edge_q <= (edge_q & ~cf_we) | (cf_d & cf_we);
      line_q <= irq_line;
      for (int i = 0; i < NUM_IRQ; i++)
        if (pr_we[i]) prio_q[i] <= req_wdata[(i%4)*8 +: 8] & PRIO_MASK;
    end
  end

  assign irq_pending = pd_q | (irq_line & ~edge_q);
  assign irq_enable  = en_q;
  assign irq_prio    = prio_q;

  always_comb begin
    logic [12:0] id;
    rw = '0;
    id = '0;
    case (region)
      2'd0: for (int j = 0; j < 32; j++) begin
        id = 13'({req_addr[6:2], 5'(j)});
        if (id < 13'(NUM_IRQ))
          case (bsel)
            3'd0, 3'd1: rw[j] = en_q[id[IW-1:0]];
            3'd2, 3'd3: rw[j] = irq_pending[id[IW-1:0]];
            3'd4, 3'd5: rw[j] = ac_q[id[IW-1:0]];
            default:    rw[j] = 1'b0;
          endcase
      end
      2'd1: for (int k = 0; k < 4; k++) begin
        id = 13'({req_addr[9:2], 2'(k)});
        if (id < 13'(NUM_IRQ)) rw[k*8 +: 8] = prio_q[id[IW-1:0]];
      end
      2'd2: for (int k = 0; k < 16; k++) begin
        id = 13'({req_addr[9:2], 4'(k)});
        if (id < 13'(NUM_IRQ)) rw[2*k+1] = edge_q[id[IW-1:0]];
      end
      default: rw = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= req_valid && !req_write;
      rd_data  <= (req_valid && !req_write) ? (rw & bmask) : 32'd0;
    end
  end
endmodule

// File: rtl/irq_state_bank_chk.sv
module irq_state_bank_chk #(
  parameter int NUM_IRQ   = 64,
  parameter int PRIO_BITS = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_write,
  input logic [1:0]           req_size,
  input logic [11:0]          req_addr,
  input logic [31:0]          req_wdata,
  input logic                 rd_valid,
  input logic [31:0]          rd_data,
  input logic [NUM_IRQ-1:0]   irq_line,
  input logic [NUM_IRQ-1:0]   irq_pending,
  input logic [NUM_IRQ-1:0]   irq_enable,
  input logic [NUM_IRQ*8-1:0] irq_prio
);
  localparam logic [7:0] LOWBITS = ~(8'(8'hFF << (8 - PRIO_BITS)));

  function automatic logic [NUM_IRQ*8-1:0] low_rep();
    logic [NUM_IRQ*8-1:0] r;
    for (int i = 0; i < NUM_IRQ; i++) r[i*8 +: 8] = LOWBITS;
    return r;
  endfunction

  localparam logic [NUM_IRQ*8-1:0] LOWREP = low_rep();

  logic word_wr, word_rd;
  assign word_wr = req_valid && req_write && (req_size == 2'd2);
  assign word_rd = req_valid && !req_write && (req_size == 2'd2);

  assert_rd_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid == $past(req_valid && !req_write));

  assert_prio_low_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_prio & LOWREP) == '0);

  assert_level_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_line[31:16] & ~irq_pending[31:16]) == 16'h0);

  assert_edge_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending[0] && !(req_valid && req_write && req_addr[11:7] == 5'b00011) |=> irq_pending[0]);

  assert_enable_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    word_wr && req_addr == 12'h000 && req_wdata[0] |=> irq_enable[0]);

  assert_enable_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    word_wr && req_addr == 12'h080 && req_wdata[0] |=> !irq_enable[0]);

  assert_cfg_edge_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    word_rd && req_addr == 12'h800 |=> rd_data == 32'hAAAA_AAAA);

  assert_cfg_level_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    word_rd && req_addr == 12'h804 |=> rd_data == 32'h0);
endmodule

bind irq_state_bank irq_state_bank_chk #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
  .rd_valid(rd_valid), .rd_data(rd_data), .irq_line(irq_line),
  .irq_pending(irq_pending), .irq_enable(irq_enable), .irq_prio(irq_prio)
);

// File: tb/irq_state_bank_test.sv
module irq_state_bank_test;
  localparam int N = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_size = 2'd0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rd_valid;
  logic [31:0] rd_data;
  logic [N-1:0] irq_line = '0;
  logic [N-1:0] irq_pending, irq_enable;
  logic [N*8-1:0] irq_prio;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  irq_state_bank #(.NUM_IRQ(N), .PRIO_BITS(5)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .irq_line(irq_line),
    .irq_pending(irq_pending), .irq_enable(irq_enable), .irq_prio(irq_prio)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = s; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [1:0] s, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = s;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 rd_valid", 64'(rd_valid), 64'd1);
    d = rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R9 enable port", irq_enable, 64'd0);
    chk("R9 pending port", irq_pending, 64'd0);
    rd(12'h100, 2'd2, d); chk("R9 pending reg", 64'(d), 64'd0);
    rd(12'h400, 2'd2, d); chk("R9 priority", 64'(d), 64'd0);
    rd(12'h800, 2'd2, d); chk("R6 private edge cfg", 64'(d), 64'hAAAA_AAAA);
    rd(12'h808, 2'd2, d); chk("R9 shared level cfg", 64'(d), 64'd0);
  endtask

  task automatic t_set_clear();
    logic [31:0] d;
    wr(12'h004, 2'd2, 32'h5);
    chk("R1 enable set", irq_enable, 64'h0000_0005_0000_0000);
    wr(12'h004, 2'd2, 32'h0);
    chk("R1 zero no effect", irq_enable, 64'h0000_0005_0000_0000);
    rd(12'h084, 2'd2, d); chk("R3 clear reg reads state", 64'(d), 64'h5);
    wr(12'h084, 2'd2, 32'h1);
    chk("R2 enable clear", irq_enable, 64'h0000_0004_0000_0000);
    wr(12'h200, 2'd2, 32'h8000_0001);
    rd(12'h280, 2'd2, d); chk("R3 active pair", 64'(d), 64'h8000_0001);
    wr(12'h280, 2'd2, 32'h1);
    rd(12'h200, 2'd2, d); chk("R2 active clear", 64'(d), 64'h8000_0000);
  endtask

  task automatic t_prio();
    logic [31:0] d;
    wr(12'h400, 2'd2, 32'h1234_5FFF);
    rd(12'h400, 2'd2, d); chk("R4 truncation", 64'(d), 64'h1030_58F8);
    chk("R4 prio port", 64'(irq_prio[7:0]), 64'hF8);
    wr(12'h405, 2'd0, 32'hFFFF_ABFF);
    rd(12'h404, 2'd2, d); chk("R11 byte prio write", 64'(d), 64'h0000_A800);
  endtask

  task automatic t_cfg();
    logic [31:0] d;
    wr(12'h800, 2'd2, 32'h0);
    rd(12'h800, 2'd2, d); chk("R6 edge locked", 64'(d), 64'hAAAA_AAAA);
    wr(12'h804, 2'd2, 32'hFFFF_FFFF);
    rd(12'h804, 2'd2, d); chk("R6 level locked", 64'(d), 64'h0);
    wr(12'h808, 2'd2, 32'h3);
    rd(12'h808, 2'd2, d); chk("R5 shared edge cfg", 64'(d), 64'h2);
  endtask

  task automatic t_level();
    logic [31:0] d;
    @(negedge clk); irq_line[40] = 1'b1; #1;
    chk("R7 line high pending", 64'(irq_pending[40]), 64'd1);
    rd(12'h104, 2'd2, d); chk("R7 pending reg", 64'(d), 64'h100);
    @(negedge clk); irq_line[40] = 1'b0; #1;
    chk("R7 line low", 64'(irq_pending[40]), 64'd0);
    wr(12'h104, 2'd2, 32'h100);
    chk("R1 pending set latch", 64'(irq_pending[40]), 64'd1);
    wr(12'h184, 2'd2, 32'h100);
    chk("R2 pending clear latch", 64'(irq_pending[40]), 64'd0);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    @(negedge clk); irq_line[32] = 1'b1; irq_line[0] = 1'b1;
    @(negedge clk);
    chk("R8 rising latches shared", 64'(irq_pending[32]), 64'd1);
    chk("R8 rising latches private", 64'(irq_pending[0]), 64'd1);
    irq_line[32] = 1'b0; irq_line[0] = 1'b0;
    @(negedge clk);
    chk("R8 latch holds", 64'(irq_pending[32]), 64'd1);
    rd(12'h104, 2'd2, d); chk("R8 pending reg", 64'(d), 64'h1);
    wr(12'h184, 2'd2, 32'h1);
    chk("R8 cleared", 64'(irq_pending[32]), 64'd0);
    wr(12'h180, 2'd2, 32'h1);
    chk("R8 private cleared", 64'(irq_pending[0]), 64'd0);
  endtask

  task automatic t_lanes();
    logic [31:0] d;
    wr(12'h002, 2'd1, 32'h0003_FFFF);
    wr(12'h001, 2'd2, 32'hFFFF_FFFF);
    wr(12'h000, 2'd0, 32'hFFFF_FF00);
    wr(12'h003, 2'd1, 32'hFFFF_FFFF);
    rd(12'h000, 2'd2, d); chk("R11 lanes and misaligned", 64'(d), 64'h0003_0000);
    rd(12'h002, 2'd0, d); chk("R11 byte read lane", 64'(d), 64'h0003_0000);
    rd(12'h001, 2'd2, d); chk("R11 misaligned read", 64'(d), 64'h0);
  endtask

  task automatic t_range();
    logic [31:0] d;
    wr(12'h008, 2'd2, 32'hFFFF_FFFF);
    rd(12'h008, 2'd2, d); chk("R12 enable out of range", 64'(d), 64'h0);
    chk("R12 enable port", irq_enable, 64'h0000_0004_0003_0000);
    wr(12'h440, 2'd2, 32'hFFFF_FFFF);
    rd(12'h440, 2'd2, d); chk("R12 prio out of range", 64'(d), 64'h0);
  endtask

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_set_clear();
    t_prio();
    t_cfg();
    t_level();
    t_edge();
    t_lanes();
    t_range();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule